// File: doc/BRIEF.md
# Direct-Mapped Block Cache

This block is a direct-mapped cache placed between a processor load/store port and a slower main memory. Every byte address maps to exactly one line. Each line holds a block of four 32-bit words, together with a valid bit, a dirty bit and a tag. On a miss the whole block is refilled. The refill sends one block-aligned address, and memory then streams back the four words.

The processor raises a read or write strobe and holds its address and data while `cpuStall` is high. A hit finishes in the cycle it is presented. A miss stalls the processor until the refilled line can serve it. The parameter `WRITE_BACK` selects the store policy. In write-back mode, a store hit only marks the line dirty, and a dirty victim is copied out before the refill, so a load can cause memory writes. In write-through mode, every store is also sent to memory. Both modes allocate on a store miss, so a store can cause a memory read.

The address splits into byte offset [1:0], word offset [3:2], index [INDEX_W+3:4] and tag above that. With `INDEX_W` = 12 the cache has 4K lines and a 16-bit tag. The default is 8.

Top module: `blk_cache`

## Requirements
- R1: After reset no line is valid, so the first access to any line stalls and refills.
- R2: Address bits [1:0] are ignored. Word offset [3:2] selects the word within a block, and the index bits select the line. Two addresses with the same index and different tags replace each other.
- R3: A miss raises `memRdReq` for exactly one cycle, with `memAddr` equal to the block-aligned address (low four bits zero). It then stores the next four `memRvalid` words as words 0, 1, 2, 3 of the line.
- R4: A hit completes with `cpuStall` low in the cycle it is presented, and read data comes from the addressed word. A miss holds `cpuStall` high until the refill completes.
- R5: In write-back mode, a store hit updates the cached word without stalling and without any memory request.
- R6: In write-back mode, a miss whose victim is dirty first writes the four victim words to the victim's addresses, then refills. This holds for loads as well as stores.
- R7: A clean victim is never written to memory.
- R8: A store miss refills the block from memory, then merges the stored word. The other three words keep their memory values.
- R9: In write-through mode, each store sends the word to memory at its word-aligned address and stalls until `memWrAck`. Evictions cause no writes.
- R10: `memWrReq` stays high, with `memAddr` and `memWrData` stable, until `memWrAck`. `memRdReq` and `memWrReq` are never high together. No memory request is raised in the cycle after an access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuAddr | input | 32 | Processor byte address |
| cpuRd | input | 1 | Load strobe |
| cpuWr | input | 1 | Store strobe |
| cpuWdata | input | 32 | Store data |
| cpuRdata | output | 32 | Load data, valid when not stalled |
| cpuStall | output | 1 | Processor must hold its request |
| memAddr | output | 32 | Block address for refills, word address for writes |
| memRdReq | output | 1 | One-cycle burst read request |
| memRvalid | input | 1 | A refill word is present |
| memRdata | input | 32 | Refill word |
| memWrReq | output | 1 | Word write request, held until acknowledged |
| memWrData | output | 32 | Word to write |
| memWrAck | input | 1 | Memory accepts the current write |

## Verification
The bench runs a write-back instance and a write-through instance, each with its own behavioural memory. Each memory returns an address-derived pattern and leaves gaps in the refill stream.

- **Loads:** cold misses, hits on all four words and hits with nonzero byte offsets tell hit from miss timing and catch fill-order errors.
- **Conflicting tags on one index:** these separate dirty evictions (four writes, carrying the stored value) from clean ones (none).
- **Store misses:** these show that a store fetches the block and keeps the memory values of its neighbours.
- **Write-through stores:** the same store sequences on the write-through instance show exactly one memory write per store and no eviction traffic.

// File: rtl/blk_cache_pkg.sv
package blk_cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_REQ,
    ST_FILL,
    ST_THRU
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic fillWe;    // write refill word at wordIdx
    logic fillDone;  // last refill word: set valid and tag, clear dirty
    logic cpuWe;     // write store data at the addressed word
    logic evictSel;  // memory port carries a victim word
    logic thruSel;   // memory port carries a write-through word
  } dpStrobe_t;

endpackage

// File: rtl/blk_cache_dpath.sv
module blk_cache_dpath
  import blk_cache_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int INDEX_W    = 8,
  parameter int OFS_W      = 2,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [31:0]                    cpuAddr,
  input  logic [DATA_W-1:0]              cpuWdata,
  input  logic [DATA_W-1:0]              memRdata,
  input  dpStrobe_t                      strb,
  input  logic [OFS_W-1:0]               wordIdx,
  output logic                           hit,
  output logic                           victimDirty,
  output logic [30-INDEX_W-OFS_W-1:0]    victimTag,
  output logic [DATA_W-1:0]              rdWord,
  output logic [DATA_W-1:0]              victimWord
);

  localparam int LINES = 1 << INDEX_W;
  localparam int WORDS = 1 << OFS_W;
  localparam int TAG_W = 30 - INDEX_W - OFS_W;

  logic [LINES-1:0]   validQ, dirtyQ;
  logic [TAG_W-1:0]   tagMem  [LINES];
  logic [DATA_W-1:0]  dataMem [LINES*WORDS];

  logic [INDEX_W-1:0] idx;
  logic [TAG_W-1:0]   tagIn;
  logic [OFS_W-1:0]   ofs;

  assign idx   = cpuAddr[2+OFS_W +: INDEX_W];
  assign tagIn = cpuAddr[31 -: TAG_W];
  assign ofs   = cpuAddr[2 +: OFS_W];

  assign victimTag   = tagMem[idx];
  assign hit         = validQ[idx] && (tagMem[idx] == tagIn);
  assign victimDirty = validQ[idx] && dirtyQ[idx];
  assign rdWord      = dataMem[{idx, ofs}];
  assign victimWord  = dataMem[{idx, wordIdx}];

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
      dirtyQ <= '0;
    end else if (strb.fillDone) begin
      validQ[idx] <= 1'b1;
      dirtyQ[idx] <= 1'b0;
    end else if (strb.cpuWe && WRITE_BACK) begin
      dirtyQ[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fillDone) tagMem[idx] <= tagIn;
    if (strb.fillWe) dataMem[{idx, wordIdx}] <= memRdata;
    else if (strb.cpuWe) dataMem[{idx, ofs}] <= cpuWdata;
  end

endmodule

// File: rtl/blk_cache_ctrl.sv
module blk_cache_ctrl
  import blk_cache_pkg::*;
#(
  parameter int OFS_W      = 2,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpuRd,
  input  logic             cpuWr,
  input  logic             hit,
  input  logic             victimDirty,
  input  logic             memRvalid,
  input  logic             memWrAck,
  output dpStrobe_t        strb,
  output logic [OFS_W-1:0] wordIdx,
  output logic             memRdReq,
  output logic             memWrReq,
  output logic             cpuStall
);

  ctlState_t        state, stateNext;
  logic [OFS_W-1:0] cnt;
  logic             cntInc;
  logic             lastWord;

  assign lastWord = (cnt == {OFS_W{1'b1}});
  assign wordIdx  = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      if (cntInc) cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    cntInc    = 1'b0;
    memRdReq  = 1'b0;
    memWrReq  = 1'b0;
    cpuStall  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if ((cpuRd || cpuWr) && !hit) begin
          cpuStall  = 1'b1;
          stateNext = (WRITE_BACK && victimDirty) ? ST_EVICT : ST_REQ;
        end else if (cpuWr && hit) begin
          strb.cpuWe = 1'b1;
          if (!WRITE_BACK) begin
            cpuStall  = 1'b1;
            stateNext = ST_THRU;
          end
        end
      end
      ST_EVICT: begin
        cpuStall      = 1'b1;
        memWrReq      = 1'b1;
        strb.evictSel = 1'b1;
        if (memWrAck) begin
          cntInc = 1'b1;
          if (lastWord) stateNext = ST_REQ;
        end
      end
      ST_REQ: begin
        cpuStall  = 1'b1;
        memRdReq  = 1'b1;
        stateNext = ST_FILL;
      end
      ST_FILL: begin
        cpuStall = 1'b1;
        if (memRvalid) begin
          strb.fillWe = 1'b1;
          cntInc      = 1'b1;
          if (lastWord) begin
            strb.fillDone = 1'b1;
            stateNext     = ST_IDLE;
          end
        end
      end
      ST_THRU: begin
        memWrReq     = 1'b1;
        strb.thruSel = 1'b1;
        cpuStall     = !memWrAck;
        if (memWrAck) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/blk_cache.sv
module blk_cache
  import blk_cache_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int INDEX_W    = 8,
  parameter int OFS_W      = 2,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuStall,
  output logic [31:0]       memAddr,
  output logic              memRdReq,
  input  logic              memRvalid,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memWrReq,
  output logic [DATA_W-1:0] memWrData,
  input  logic              memWrAck
);

  localparam int TAG_W = 30 - INDEX_W - OFS_W;

  dpStrobe_t          strb;
  logic [OFS_W-1:0]   wordIdx;
  logic               hit, victimDirty;
  logic [TAG_W-1:0]   victimTag;
  logic [DATA_W-1:0]  victimWord;

  blk_cache_ctrl #(.OFS_W(OFS_W), .WRITE_BACK(WRITE_BACK)) ctrlU (
    .clk(clk), .rst(rst), .cpuRd(cpuRd), .cpuWr(cpuWr), .hit(hit),
    .victimDirty(victimDirty), .memRvalid(memRvalid), .memWrAck(memWrAck),
    .strb(strb), .wordIdx(wordIdx), .memRdReq(memRdReq),
    .memWrReq(memWrReq), .cpuStall(cpuStall)
  );

  blk_cache_dpath #(.DATA_W(DATA_W), .INDEX_W(INDEX_W), .OFS_W(OFS_W),
                    .WRITE_BACK(WRITE_BACK)) dpathU (
    .clk(clk), .rst(rst), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .memRdata(memRdata), .strb(strb), .wordIdx(wordIdx), .hit(hit),
    .victimDirty(victimDirty), .victimTag(victimTag), .rdWord(cpuRdata),
    .victimWord(victimWord)
  );

  always_comb begin
    memAddr = '0;
    if (strb.evictSel)
      memAddr = {victimTag, cpuAddr[2+OFS_W +: INDEX_W], wordIdx, 2'b00};
    else if (strb.thruSel)
      memAddr = {cpuAddr[31:2], 2'b00};
    else if (memRdReq)
      memAddr = {cpuAddr[31:2+OFS_W], {(OFS_W+2){1'b0}}};
  end

  assign memWrData = strb.evictSel ? victimWord : cpuWdata;

endmodule

// File: rtl/blk_cache_chk.sv
module blk_cache_chk #(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cpuRd,
  input logic              cpuWr,
  input logic              cpuStall,
  input logic [31:0]       memAddr,
  input logic              memRdReq,
  input logic              memWrReq,
  input logic [DATA_W-1:0] memWrData,
  input logic              memWrAck
);

  // R3
  single_rdreq_chk: assert property (@(posedge clk) disable iff (rst)
    memRdReq |=> !memRdReq);

  // R3
  aligned_rdaddr_chk: assert property (@(posedge clk) disable iff (rst)
    memRdReq |-> memAddr[OFS_W+1:0] == '0);

  // R4
  stall_on_rd_chk: assert property (@(posedge clk) disable iff (rst)
    memRdReq |-> cpuStall);

  // R10
  no_dual_req_chk: assert property (@(posedge clk) disable iff (rst)
    !(memRdReq && memWrReq));

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (memWrReq && !memWrAck) |=> (memWrReq && $stable(memAddr) && $stable(memWrData)));

  // R10
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    ((cpuRd || cpuWr) && !cpuStall) |=> (!memRdReq && !memWrReq));

endmodule

bind blk_cache blk_cache_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W)) chkU (
  .clk(clk), .rst(rst), .cpuRd(cpuRd), .cpuWr(cpuWr), .cpuStall(cpuStall),
  .memAddr(memAddr), .memRdReq(memRdReq), .memWrReq(memWrReq),
  .memWrData(memWrData), .memWrAck(memWrAck)
);

// File: tb/blk_cache_test.sv
`timescale 1ns/1ps

module tb_mem_model (
  input  logic        clk,
  input  logic        rdReq,
  input  logic        wrReq,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic        rvalid,
  output logic [31:0] rdata,
  output logic        wrAck
);
  logic [31:0] store [logic [31:0]];
  int          rdCount = 0;
  int          wrCount = 0;
  logic [31:0] lastRdAddr = '0;
  logic [31:0] lastWrAddr = '0;
  logic [31:0] rdBase = '0;
  bit          rdBusy = 0;
  int          phase = 0;
  int          nOut = 0;
  int          wDly = 0;

  function automatic logic [31:0] peek(input logic [31:0] a);
    logic [31:0] k;
    k = {a[31:2], 2'b00};
    if (store.exists(k)) return store[k];
    return k ^ 32'h5A5A_0000;
  endfunction

  initial begin
    rvalid = 1'b0;
    rdata  = '0;
    wrAck  = 1'b0;
  end

  always @(negedge clk) begin
    rvalid <= 1'b0;
    wrAck  <= 1'b0;
    if (wrReq && !wrAck) begin
      if (wDly == 2) begin
        wrAck <= 1'b1;
        store[{addr[31:2], 2'b00}] = wdata;
        lastWrAddr = addr;
        wrCount++;
        wDly = 0;
      end else wDly++;
    end
    if (rdReq && !rdBusy) begin
      rdBusy = 1;
      rdBase = addr;
      lastRdAddr = addr;
      rdCount++;
      phase = 0;
      nOut = 0;
    end else if (rdBusy) begin
      phase++;
      if (phase >= 3 && phase[0]) begin
        rvalid <= 1'b1;
        rdata  <= peek(rdBase + 32'(nOut * 4));
        nOut++;
        if (nOut == 4) rdBusy = 0;
      end
    end
  end
endmodule

module blk_cache_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int nChecks = 0;
  int nErr = 0;

  logic [31:0] addrW = '0, wdW = '0, addrT = '0, wdT = '0;
  logic        rdW = 0, wrW = 0, rdT = 0, wrT = 0;
  logic [31:0] rdataW, rdataT, mAddrW, mAddrT, mWdW, mWdT, mRdW, mRdT;
  logic        stallW, stallT, mRqW, mRqT, mWqW, mWqT, mRvW, mRvT, mAkW, mAkT;

  blk_cache #(.WRITE_BACK(1'b1)) uut (
    .clk(clk), .rst(rst), .cpuAddr(addrW), .cpuRd(rdW), .cpuWr(wrW),
    .cpuWdata(wdW), .cpuRdata(rdataW), .cpuStall(stallW), .memAddr(mAddrW),
    .memRdReq(mRqW), .memRvalid(mRvW), .memRdata(mRdW), .memWrReq(mWqW),
    .memWrData(mWdW), .memWrAck(mAkW)
  );
  tb_mem_model memW (
    .clk(clk), .rdReq(mRqW), .wrReq(mWqW), .addr(mAddrW), .wdata(mWdW),
    .rvalid(mRvW), .rdata(mRdW), .wrAck(mAkW)
  );

  blk_cache #(.WRITE_BACK(1'b0)) uutThru (
    .clk(clk), .rst(rst), .cpuAddr(addrT), .cpuRd(rdT), .cpuWr(wrT),
    .cpuWdata(wdT), .cpuRdata(rdataT), .cpuStall(stallT), .memAddr(mAddrT),
    .memRdReq(mRqT), .memRvalid(mRvT), .memRdata(mRdT), .memWrReq(mWqT),
    .memWrData(mWdT), .memWrAck(mAkT)
  );
  tb_mem_model memT (
    .clk(clk), .rdReq(mRqT), .wrReq(mWqT), .addr(mAddrT), .wdata(mWdT),
    .rvalid(mRvT), .rdata(mRdT), .wrAck(mAkT)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_0000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input bit wt, input bit isWr, input logic [31:0] a,
                        input logic [31:0] d, output logic [31:0] rd, output int stalls);
    @(negedge clk);
    if (wt) begin addrT = a; rdT = !isWr; wrT = isWr; wdT = d; end
    else    begin addrW = a; rdW = !isWr; wrW = isWr; wdW = d; end
    stalls = 0;
    #2;
    while ((wt ? stallT : stallW) && stalls < 500) begin
      stalls++;
      @(negedge clk);
      #2;
    end
    rd = wt ? rdataT : rdataW;
    @(posedge clk);
    #1;
    rdT = 0; wrT = 0; rdW = 0; wrW = 0;
  endtask

  task automatic testReset();
    logic [31:0] rd; int st; int r0;
    #3;
    check("R1 reset stall", {31'b0, stallW}, 32'd0);
    check("R10 reset no read request", {31'b0, mRqW}, 32'd0);
    r0 = memW.rdCount;
    access(0, 0, 32'h0000_1234, 0, rd, st);
    check("R1 cold access misses", {31'b0, st > 0}, 32'd1);
    check("R3 one refill per miss", memW.rdCount - r0, 32'd1);
    check("R3 block-aligned read address", memW.lastRdAddr, 32'h0000_1230);
    check("R4 miss returns word", rd, pat(32'h0000_1234));
  endtask

  task automatic testHits();
    logic [31:0] rd; int st;
    for (int w = 0; w < 4; w++) begin
      access(0, 0, 32'h0000_1230 + 32'(w * 4), 0, rd, st);
      check("R3 fill order word", rd, pat(32'h0000_1230 + 32'(w * 4)));
      check("R4 hit without stall", st, 32'd0);
    end
    access(0, 0, 32'h0000_1237, 0, rd, st);
    check("R2 byte offset ignored", rd, pat(32'h0000_1234));
    check("R2 byte offset still hits", st, 32'd0);
  endtask

  task automatic testWbStore();
    logic [31:0] rd; int st; int w0;
    w0 = memW.wrCount;
    access(0, 1, 32'h0000_1238, 32'hDEAD_0001, rd, st);
    check("R5 store hit no stall", st, 32'd0);
    check("R5 store hit no memory write", memW.wrCount - w0, 32'd0);
    access(0, 0, 32'h0000_1238, 0, rd, st);
    check("R5 store hit readback", rd, 32'hDEAD_0001);
  endtask

  task automatic testDirtyEvict();
    logic [31:0] rd; int st; int w0; int r0;
    w0 = memW.wrCount; r0 = memW.rdCount;
    access(0, 0, 32'h0000_2238, 0, rd, st);
    check("R6 load evicts four dirty words", memW.wrCount - w0, 32'd4);
    check("R6 stored word written back", memW.peek(32'h0000_1238), 32'hDEAD_0001);
    check("R6 victim word 0 address", memW.peek(32'h0000_1230), pat(32'h0000_1230));
    check("R6 refill after eviction", memW.rdCount - r0, 32'd1);
    check("R2 conflicting tag replaces line", rd, pat(32'h0000_2238));
  endtask

  task automatic testStoreMiss();
    logic [31:0] rd; int st; int w0; int r0;
    w0 = memW.wrCount; r0 = memW.rdCount;
    access(0, 1, 32'h0000_3234, 32'hBEEF_0002, rd, st);
    check("R8 store miss reads block", memW.rdCount - r0, 32'd1);
    check("R7 clean victim not written", memW.wrCount - w0, 32'd0);
    check("R8 store miss leaves memory", memW.peek(32'h0000_3234), pat(32'h0000_3234));
    access(0, 0, 32'h0000_3230, 0, rd, st);
    check("R8 neighbour word from memory", rd, pat(32'h0000_3230));
    access(0, 0, 32'h0000_3234, 0, rd, st);
    check("R8 merged store word", rd, 32'hBEEF_0002);
    w0 = memW.wrCount;
    access(0, 0, 32'h0000_4234, 0, rd, st);
    check("R6 store-miss line is dirty", memW.wrCount - w0, 32'd4);
    check("R6 merged word written back", memW.peek(32'h0000_3234), 32'hBEEF_0002);
  endtask

  task automatic testCleanEvict();
    logic [31:0] rd; int st; int w0;
    access(0, 0, 32'h0000_5040, 0, rd, st);
    w0 = memW.wrCount;
    access(0, 0, 32'h0000_6040, 0, rd, st);
    check("R7 clean conflict no write", memW.wrCount - w0, 32'd0);
    check("R7 conflict data", rd, pat(32'h0000_6040));
  endtask

  task automatic testThruStore();
    logic [31:0] rd; int st; int w0;
    access(1, 0, 32'h0000_1234, 0, rd, st);
    w0 = memT.wrCount;
    access(1, 1, 32'h0000_1234, 32'hCAFE_0003, rd, st);
    check("R9 store writes one word", memT.wrCount - w0, 32'd1);
    check("R9 store stalls until ack", {31'b0, st > 0}, 32'd1);
    check("R9 write address", memT.lastWrAddr, 32'h0000_1234);
    check("R9 memory holds store", memT.peek(32'h0000_1234), 32'hCAFE_0003);
    access(1, 0, 32'h0000_1234, 0, rd, st);
    check("R9 cache holds store", rd, 32'hCAFE_0003);
    w0 = memT.wrCount;
    access(1, 0, 32'h0000_2234, 0, rd, st);
    check("R9 eviction writes nothing", memT.wrCount - w0, 32'd0);
    check("R9 conflict data", rd, pat(32'h0000_2234));
  endtask

  task automatic testThruStoreMiss();
    logic [31:0] rd; int st; int w0; int r0;
    w0 = memT.wrCount; r0 = memT.rdCount;
    access(1, 1, 32'h0000_7238, 32'hF00D_0004, rd, st);
    check("R8 write-through store miss reads", memT.rdCount - r0, 32'd1);
    check("R9 store miss writes one word", memT.wrCount - w0, 32'd1);
    check("R9 store miss memory value", memT.peek(32'h0000_7238), 32'hF00D_0004);
    access(1, 0, 32'h0000_723C, 0, rd, st);
    check("R8 neighbour after store miss", rd, pat(32'h0000_723C));
    check("R4 neighbour hits", st, 32'd0);
  endtask

  task automatic finish();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL R4 watchdog: actual hung expected completion");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    testReset();
    testHits();
    testWbStore();
    testDirtyEvict();
    testStoreMiss();
    testCleanEvict();
    testThruStore();
    testThruStoreMiss();
    repeat (4) @(posedge clk);
    finish();
  end
endmodule